// File: doc/BRIEF.md
# Load/Store Unit with Atomic Test-and-Set

This block is the memory access stage of a small 32-bit RISC core. Each cycle it can accept one operation from the core. The operation is a PC-relative word load, a pointer load or store of byte, halfword or word, or an atomic test-and-set on a single byte. It converts each operation into a request on a simple synchronous memory port, which carries a word address, byte-lane enables, write data and read data returned one cycle after the request. It returns load results to the core, and test-and-set also returns a truth-flag update.

Loads and stores are pipelined, so a new one can be accepted every cycle. A test-and-set reads the target byte and returns it with a flag that is set when the byte was free (bit 7 clear). It then writes the byte back with bit 7 forced high. The unit accepts no other request until that write has been issued, so no other access can slip between the read and the write.

Top module: `mem_access_unit`

## Requirements
- R1: With `req_op` = 0 (PC-relative load), the effective address is `req_pc` plus the sign-extended `req_imm` shifted left by one. A full word is read from the word containing that address, with the low two address bits ignored.
- R2: With `req_op` = 1 (pointer load), `req_ptr` is the byte address. `req_size` 000 returns the addressed byte, 001 returns the halfword selected by address bit 1, and any other code returns the whole word. Byte and halfword results are zero-extended, and lanes are little-endian: byte address bits [1:0] select lane 0 to 3.
- R3: With `req_op` = 2 (store), `req_ptr` is the byte address and `req_wdata` is the data. Byte stores enable only the addressed lane, halfword stores enable lanes 1:0 or 3:2 by address bit 1, and other size codes enable all four lanes. Lanes not enabled keep their contents in memory.
- R4: A store request appears on the memory port (`mem_req`=1, `mem_we`=1) in the cycle after acceptance, and it produces no response.
- R5: A load response (`rsp_valid`=1) appears in the third cycle after acceptance. A new load can be accepted every cycle.
- R6: With `req_op` = 3 (test-and-set), the response carries the addressed byte zero-extended. It also raises `flag_upd` with `flag_val`=1 when bit 7 of the byte was 0, and `flag_val`=0 otherwise.
- R7: A test-and-set issues its read in the cycle after acceptance, leaves the port idle for one cycle, and then issues a one-lane write of the byte with bit 7 set. `ready` stays low for those three cycles, and requests offered while `ready` is low are ignored.
- R8: `flag_upd` is raised only for test-and-set responses. PC-relative loads, pointer loads and stores leave the flag untouched.
- R9: While `rst_n` is low, `ready`, `mem_req`, `rsp_valid` and `flag_upd` are all 0. `ready` rises within three cycles after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers an operation |
| req_op | input | 2 | 0 PC-relative load, 1 pointer load, 2 store, 3 test-and-set |
| req_size | input | 3 | Access size code for pointer load/store |
| req_ptr | input | ADDR_W | Pointer register value (byte address) |
| req_wdata | input | DATA_W | Store data register value |
| req_pc | input | ADDR_W | Program counter for PC-relative load |
| req_imm | input | IMM_W | Signed offset for PC-relative load |
| ready | output | 1 | Operation is accepted when high together with req_valid |
| rsp_valid | output | 1 | Load or test-and-set result is valid |
| rsp_data | output | DATA_W | Zero-extended load result |
| flag_upd | output | 1 | Truth flag must be written |
| flag_val | output | 1 | New truth flag value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | DATA_W/8 | Byte-lane write enables |
| mem_wdata | output | DATA_W | Lane-replicated write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
Two cases can share a cycle. In the first, a load's response returns in the same cycle that a test-and-set accepted one cycle later is in its idle gap. The bench provokes this by offering the two operations back to back, and judges it by a response without a flag update followed one cycle later by a response that carries one. In the second, a store's write reaches memory in the same cycle that the next load is accepted. The bench provokes this with a store and a load of the same word on consecutive cycles, and judges it by whether the load returns the freshly stored value. A store offered during the test-and-set busy window is checked against memory to confirm it was dropped.

// File: rtl/mau_pkg.sv
`timescale 1ns/1ps
package mau_pkg;

  typedef enum logic [1:0] {
    OP_PCREL = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_TAS   = 2'd3
  } mau_op_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_w_e;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_READ  = 2'd1,
    TS_HOLD  = 2'd2,
    TS_WRITE = 2'd3
  } tas_state_e;

  typedef struct packed {
    logic       valid;
    logic       is_tas;
    acc_w_e     width;
    logic [1:0] lane;
  } rd_tag_t;

endpackage

// File: rtl/mau_addr_gen.sv
`timescale 1ns/1ps
module mau_addr_gen
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  mau_op_e           op_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] addr_o,
  output acc_w_e            width_o
);

  localparam int EXT_W = ADDR_W - IMM_W - 1;

  logic [ADDR_W-1:0] pc_offset;

  // signed immediate counts halfwords
  assign pc_offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 1'b0};

  always_comb begin
    addr_o  = ptr_i;
    width_o = ACC_WORD;
    unique case (op_i)
      OP_PCREL: begin
        addr_o  = pc_i + pc_offset;
        width_o = ACC_WORD;
      end
      OP_TAS: begin
        width_o = ACC_BYTE;
      end
      default: begin
        if (size_i == SZ_BYTE)      width_o = ACC_BYTE;
        else if (size_i == SZ_HALF) width_o = ACC_HALF;
        else                        width_o = ACC_WORD;
      end
    endcase
  end

endmodule

// File: rtl/mau_store_lanes.sv
`timescale 1ns/1ps
module mau_store_lanes
  import mau_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_w_e                         width_i,
  input  logic [$clog2(DATA_W/8)-1:0]    lane_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [DATA_W/8-1:0]            be_o,
  output logic [DATA_W-1:0]              data_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(g);
    localparam logic [OFF_W-2:0] PAIR_ID = (OFF_W-1)'(g / 2);

    always_comb begin
      unique case (width_i)
        ACC_BYTE: begin
          be_o[g]         = (lane_i == LANE_ID);
          data_o[8*g +: 8] = data_i[7:0];
        end
        ACC_HALF: begin
          be_o[g]         = (lane_i[OFF_W-1:1] == PAIR_ID);
          data_o[8*g +: 8] = data_i[8*(g%2) +: 8];
        end
        default: begin
          be_o[g]         = 1'b1;
          data_o[8*g +: 8] = data_i[8*g +: 8];
        end
      endcase
    end
  end

endmodule

// File: rtl/mau_load_extract.sv
`timescale 1ns/1ps
module mau_load_extract
  import mau_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           rdata_i,
  input  acc_w_e                      width_i,
  input  logic [$clog2(DATA_W/8)-1:0] lane_i,
  output logic [DATA_W-1:0]           data_o
);

  localparam int OFF_W = $clog2(DATA_W / 8);

  logic [OFF_W-1:0]  base_lane;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    unique case (width_i)
      ACC_BYTE: base_lane = lane_i;
      ACC_HALF: base_lane = {lane_i[OFF_W-1:1], 1'b0};
      default:  base_lane = '0;
    endcase
  end

  assign shifted = rdata_i >> {base_lane, 3'b000};

  always_comb begin
    unique case (width_i)
      ACC_BYTE: data_o = {{(DATA_W-8){1'b0}}, shifted[7:0]};
      ACC_HALF: data_o = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default:  data_o = shifted;
    endcase
  end

endmodule

// File: rtl/mau_tas_fsm.sv
`timescale 1ns/1ps
module mau_tas_fsm
  import mau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic idle_o,
  output logic wb_issue_o
);

  tas_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE:  if (start_i) state_d = TS_READ;
      TS_READ:  state_d = TS_HOLD;
      TS_HOLD:  state_d = TS_WRITE;
      TS_WRITE: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o     = (state_q == TS_IDLE);
  // read data is present during HOLD; the write is launched from it
  assign wb_issue_o = (state_q == TS_HOLD);

endmodule

// File: rtl/mem_access_unit.sv
`timescale 1ns/1ps
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [2:0]          req_size,
  input  logic [ADDR_W-1:0]   req_ptr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [ADDR_W-1:0]   req_pc,
  input  logic [IMM_W-1:0]    req_imm,
  output logic                ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                flag_upd,
  output logic                flag_val,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);

  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int WADDR_W = ADDR_W - OFF_W;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // request decode
  mau_op_e           op;
  logic              fsm_idle;
  logic              accept;
  logic              wb_issue;
  logic [ADDR_W-1:0] eff_addr;
  acc_w_e            eff_width;
  logic [OFF_W-1:0]  eff_lane;

  assign op       = mau_op_e'(req_op);
  assign ready    = fsm_idle & core_rst_n;
  assign accept   = req_valid & ready;
  assign eff_lane = eff_addr[OFF_W-1:0];

  mau_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .op_i    (op),
    .size_i  (req_size),
    .ptr_i   (req_ptr),
    .pc_i    (req_pc),
    .imm_i   (req_imm),
    .addr_o  (eff_addr),
    .width_o (eff_width)
  );

  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_data;

  mau_store_lanes #(.DATA_W(DATA_W)) u_st_lanes (
    .width_i (eff_width),
    .lane_i  (eff_lane),
    .data_i  (req_wdata),
    .be_o    (st_be),
    .data_o  (st_data)
  );

  mau_tas_fsm u_fsm (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start_i    (accept && (op == OP_TAS)),
    .idle_o     (fsm_idle),
    .wb_issue_o (wb_issue)
  );

  // read tags: issue stage, then aligned with mem_rdata
  rd_tag_t tag_iss_d, tag_iss_q, tag_rd_q;

  always_comb begin
    tag_iss_d        = '0;
    tag_iss_d.valid  = accept && (op != OP_STORE);
    tag_iss_d.is_tas = accept && (op == OP_TAS);
    tag_iss_d.width  = eff_width;
    tag_iss_d.lane   = eff_lane;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      tag_iss_q <= '0;
      tag_rd_q  <= '0;
    end else begin
      tag_iss_q <= tag_iss_d;
      tag_rd_q  <= tag_iss_q;
    end
  end

  // returned data alignment and test-and-set write-back value
  logic [DATA_W-1:0] ld_value;
  logic [7:0]        tas_set;
  logic [LANES-1:0]  wb_be;
  logic [DATA_W-1:0] wb_data;

  mau_load_extract #(.DATA_W(DATA_W)) u_extract (
    .rdata_i (mem_rdata),
    .width_i (tag_rd_q.width),
    .lane_i  (tag_rd_q.lane),
    .data_o  (ld_value)
  );

  assign tas_set = ld_value[7:0] | 8'h80;

  mau_store_lanes #(.DATA_W(DATA_W)) u_wb_lanes (
    .width_i (ACC_BYTE),
    .lane_i  (tag_rd_q.lane),
    .data_i  ({{(DATA_W-8){1'b0}}, tas_set}),
    .be_o    (wb_be),
    .data_o  (wb_data)
  );

  // memory port: next-state
  logic               req_d, we_d;
  logic               addr_en, lane_en;
  logic [WADDR_W-1:0] addr_d;
  logic [LANES-1:0]   be_d;
  logic [DATA_W-1:0]  wdata_d;

  always_comb begin
    req_d   = accept | wb_issue;
    we_d    = wb_issue | (accept && (op == OP_STORE));
    addr_en = accept;
    addr_d  = eff_addr[ADDR_W-1:OFF_W];
    lane_en = accept | wb_issue;
    if (wb_issue) begin
      be_d    = wb_be;
      wdata_d = wb_data;
    end else if (op == OP_STORE) begin
      be_d    = st_be;
      wdata_d = st_data;
    end else begin
      be_d    = '1;
      wdata_d = st_data;
    end
  end

  // memory port: registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= req_d;
      mem_we  <= we_d;
      if (addr_en) mem_addr <= addr_d;
      if (lane_en) begin
        mem_be    <= be_d;
        mem_wdata <= wdata_d;
      end
    end
  end

  // response: next-state
  logic              rsp_en, flag_en;
  logic [DATA_W-1:0] rsp_data_d;
  logic              flag_val_d;

  always_comb begin
    rsp_en     = tag_rd_q.valid;
    flag_en    = tag_rd_q.valid & tag_rd_q.is_tas;
    rsp_data_d = ld_value;
    flag_val_d = ~ld_value[7];
  end

  // response: registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      flag_upd  <= 1'b0;
      flag_val  <= 1'b0;
    end else begin
      rsp_valid <= rsp_en;
      flag_upd  <= flag_en;
      if (rsp_en)  rsp_data <= rsp_data_d;
      if (flag_en) flag_val <= flag_val_d;
    end
  end

endmodule

// File: rtl/mau_checker.sv
`timescale 1ns/1ps
module mau_checker
  import mau_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic                ready,
  input logic                rsp_valid,
  input logic                flag_upd,
  input logic                mem_req,
  input logic                mem_we,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata
);

  logic acc, acc_ld, acc_st, acc_tas;
  assign acc     = req_valid && ready;
  assign acc_ld  = acc && ((req_op == OP_PCREL) || (req_op == OP_LOAD));
  assign acc_st  = acc && (req_op == OP_STORE);
  assign acc_tas = acc && (req_op == OP_TAS);

  // R4
  p_store_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_st |=> (mem_req && mem_we));

  // R5
  p_load_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !flag_upd) |-> $past(acc_ld, 3));

  // R3
  p_lane_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (($countones(mem_be) == 1) || (mem_be == 4'b0011) ||
                             (mem_be == 4'b1100) || (mem_be == 4'b1111)));

  // R7
  p_tas_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tas |=> (mem_req && !mem_we && !ready));

  p_tas_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tas |=> ##1 (!mem_req && !ready));

  p_tas_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tas |=> ##2 (mem_req && mem_we && ($countones(mem_be) == 1) && !ready &&
                     ((mem_wdata & 32'h80808080) == 32'h80808080)));

  // R8 and R6
  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |-> (rsp_valid && $past(acc_tas, 3)));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      p_idle_in_reset_r9: assert (!ready && !mem_req && !rsp_valid && !flag_upd);
    end
  end

endmodule

bind mem_access_unit mau_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .ready     (ready),
  .rsp_valid (rsp_valid),
  .flag_upd  (flag_upd),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata)
);

// File: tb/mem_access_unit_test.sv
`timescale 1ns/1ps
module mem_access_unit_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [2:0]  req_size;
  logic [31:0] req_ptr, req_wdata, req_pc;
  logic [7:0]  req_imm;
  logic        ready, rsp_valid, flag_upd, flag_val;
  logic [31:0] rsp_data;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [64];
  int n_run  = 0;
  int n_fail = 0;

  mem_access_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_ptr(req_ptr), .req_wdata(req_wdata),
    .req_pc(req_pc), .req_imm(req_imm), .ready(ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .flag_upd(flag_upd), .flag_val(flag_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // synchronous memory, byte at address a initialised to a
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:0]];
      end
    end
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  sz;
    logic [31:0] ptr;
    logic [31:0] wd;
    logic [31:0] pc;
    logic [7:0]  imm;
    logic [31:0] exp;
    logic        exp_f;
    logic        chk_mem;
    logic [31:0] mem_exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 32'h0,  32'h0,        32'h20, 8'h08, 32'h33323130, 1'b0, 1'b0, 32'h0},        // R1
    '{2'd0, 3'd0, 32'h0,  32'h0,        32'h40, 8'hFC, 32'h3B3A3938, 1'b0, 1'b0, 32'h0},        // R1 negative
    '{2'd1, 3'd0, 32'h45, 32'h0,        32'h0,  8'h00, 32'h00000045, 1'b0, 1'b0, 32'h0},        // R2 byte
    '{2'd1, 3'd0, 32'h87, 32'h0,        32'h0,  8'h00, 32'h00000087, 1'b0, 1'b0, 32'h0},        // R2 zero ext
    '{2'd1, 3'd1, 32'h46, 32'h0,        32'h0,  8'h00, 32'h00004746, 1'b0, 1'b0, 32'h0},        // R2 half hi
    '{2'd1, 3'd1, 32'h44, 32'h0,        32'h0,  8'h00, 32'h00004544, 1'b0, 1'b0, 32'h0},        // R2 half lo
    '{2'd1, 3'd2, 32'h48, 32'h0,        32'h0,  8'h00, 32'h4B4A4948, 1'b0, 1'b0, 32'h0},        // R2 word
    '{2'd1, 3'd3, 32'h4C, 32'h0,        32'h0,  8'h00, 32'h4F4E4D4C, 1'b0, 1'b0, 32'h0},        // R2 reserved
    '{2'd2, 3'd0, 32'h51, 32'hDEADBEEF, 32'h0,  8'h00, 32'h0,        1'b0, 1'b1, 32'h5352EF50}, // R3 byte
    '{2'd2, 3'd1, 32'h56, 32'h1234CAFE, 32'h0,  8'h00, 32'h0,        1'b0, 1'b1, 32'hCAFE5554}, // R3 half
    '{2'd2, 3'd2, 32'h58, 32'h12345678, 32'h0,  8'h00, 32'h0,        1'b0, 1'b1, 32'h12345678}, // R3 word
    '{2'd1, 3'd1, 32'h50, 32'h0,        32'h0,  8'h00, 32'h0000EF50, 1'b0, 1'b0, 32'h0},        // R3 readback
    '{2'd3, 3'd0, 32'h61, 32'h0,        32'h0,  8'h00, 32'h00000061, 1'b1, 1'b1, 32'h6362E160}, // R6 free
    '{2'd3, 3'd0, 32'h61, 32'h0,        32'h0,  8'h00, 32'h000000E1, 1'b0, 1'b1, 32'h6362E160}, // R6 taken
    '{2'd3, 3'd0, 32'h92, 32'h0,        32'h0,  8'h00, 32'h00000092, 1'b0, 1'b1, 32'h93929190}, // R6 preset
    '{2'd2, 3'd0, 32'h63, 32'h00000007, 32'h0,  8'h00, 32'h0,        1'b0, 1'b1, 32'h0762E160}  // R3 lane 3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [2:0] sz, input logic [31:0] ptr,
                       input logic [31:0] wd, input logic [31:0] pc, input logic [7:0] imm);
    req_valid = 1'b1; req_op = op; req_size = sz; req_ptr = ptr;
    req_wdata = wd; req_pc = pc; req_imm = imm;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++)
      mem[a] = {8'(4*a+3), 8'(4*a+2), 8'(4*a+1), 8'(4*a)};
    mem_rdata = '0;
    rst_n = 1'b0;
    drive(2'd0, 3'd0, 32'h0, 32'h0, 32'h0, 8'h0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!ready && !mem_req && !rsp_valid && !flag_upd, "R9 idle in reset",
          {28'h0, ready, mem_req, rsp_valid, flag_upd}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R9 ready after release", {31'h0, ready}, 32'h1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].sz, VECS[i].ptr, VECS[i].wd, VECS[i].pc, VECS[i].imm);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      if (VECS[i].op == 2'd2) begin
        check(!rsp_valid && !flag_upd, "R4 store no response",
              {30'h0, rsp_valid, flag_upd}, 32'h0);
      end else begin
        check(rsp_valid && rsp_data == VECS[i].exp, "R1/R2/R5/R6 response data",
              rsp_data, VECS[i].exp);
        if (VECS[i].op == 2'd3)
          check(flag_upd && flag_val == VECS[i].exp_f, "R6 flag",
                {30'h0, flag_upd, flag_val}, {30'h0, 1'b1, VECS[i].exp_f});
        else
          check(!flag_upd, "R8 flag untouched by load", {31'h0, flag_upd}, 32'h0);
      end
      @(negedge clk);
      @(negedge clk);
      if (VECS[i].chk_mem)
        check(mem[VECS[i].ptr[7:2]] == VECS[i].mem_exp, "R3/R7 memory word",
              mem[VECS[i].ptr[7:2]], VECS[i].mem_exp);
      check(ready, "R7 ready restored", {31'h0, ready}, 32'h1);
    end

    // load and test-and-set back to back
    drive(2'd1, 3'd2, 32'h70, 32'h0, 32'h0, 8'h0);
    @(negedge clk);
    drive(2'd3, 3'd0, 32'h74, 32'h0, 32'h0, 8'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(!ready, "R7 busy after test-and-set", {31'h0, ready}, 32'h0);
    @(negedge clk);
    check(rsp_valid && !flag_upd && rsp_data == 32'h73727170, "R5 pipelined load",
          rsp_data, 32'h73727170);
    @(negedge clk);
    check(rsp_valid && flag_upd && flag_val && rsp_data == 32'h74, "R6 pipelined tas",
          rsp_data, 32'h74);
    @(negedge clk);
    @(negedge clk);
    check(mem[29] == 32'h777675F4, "R7 write-back bit 7", mem[29], 32'h777675F4);

    // store then load of same word on consecutive cycles
    drive(2'd2, 3'd2, 32'h80, 32'hA5A50F0F, 32'h0, 8'h0);
    @(negedge clk);
    drive(2'd1, 3'd2, 32'h80, 32'h0, 32'h0, 8'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem[32] == 32'hA5A50F0F, "R4 store landed", mem[32], 32'hA5A50F0F);
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid && rsp_data == 32'hA5A50F0F, "R5 load after store",
          rsp_data, 32'hA5A50F0F);

    // request offered during busy window is dropped
    drive(2'd3, 3'd0, 32'hA0, 32'h0, 32'h0, 8'h0);
    @(negedge clk);
    drive(2'd2, 3'd2, 32'hA4, 32'hFFFFFFFF, 32'h0, 8'h0);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(mem[41] == 32'hA7A6A5A4, "R7 busy request ignored", mem[41], 32'hA7A6A5A4);
    check(mem[40] == 32'hA3A2A1A0, "R7 tas on preset byte", mem[40], 32'hA3A2A1A0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule